// File: doc/BRIEF.md
# GPIO Bank Interrupt Trigger Unit

This block turns the already-synchronized levels of a 32-pin GPIO bank into sticky per-pin interrupt status bits and one interrupt line for the whole bank. The bank is split into four ports of eight pins. Each port has a 24-bit trigger configuration word. Each pin can fire on a rising edge, a falling edge, either edge, a high level or a low level.

Status bits latch their condition whether or not the pin is enabled. The bank interrupt is the OR of all status bits whose enable is set. Software acknowledges a pin by pulsing a write-one-to-clear strobe that carries a port index and an 8-bit mask. Clearing never discards an edge that lands in the same cycle as the clear. All pins are control-style signals with no handshake: the clear strobe takes effect in the cycle it is high and cannot be stalled.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is asserted, `int_status` is all zeros and `bank_irq` is 0.
- R2: The trigger word of port p is `trig_cfg[24*p +: 24]`. For pin n of that port, bit n is the polarity (1 = high/rising), bit 8+n selects edge mode (1) or level mode (0), and bit 16+n selects both-edge mode. Pin n of port p is bank pin 8*p+n.
- R3: Code 011 (bits 16/8/0) is rising-edge mode. The status bit is set at the clock edge where the pin is 1 and its value sampled at the previous edge was 0. The previous value is taken as 0 at the first edge after reset.
- R4: Code 010 is falling-edge mode. The status bit is set at the clock edge where the pin is 0 and its previous sample was 1. A rising edge does not set it.
- R5: Code 110 is both-edge mode. Any change between the previous sample and the current level sets the status bit.
- R6: Code 001 is level-high mode and code 000 is level-low mode. The status bit is set at every edge where the pin matches the polarity. A clear issued while the level still matches leaves the bit set.
- R7: When `clr_we` is 1, each 1 bit n in `clr_mask` clears status bit n of port `clr_port` at that clock edge, unless its condition is present in that cycle. Mask bits at 0 and the other ports are unaffected.
- R8: An edge that arrives in the same cycle as a clear of that pin leaves the status bit set.
- R9: Status bits are set regardless of `irq_en`. `bank_irq` is 1 exactly when some bit of `int_status & irq_en` is 1, in the same cycle as the status register.
- R10: Any of the 32 pins, in any of the four ports, can raise the single `bank_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronized pin levels, bank pin order |
| irq_en | input | 32 | Per-pin interrupt enable |
| trig_cfg | input | 96 | Four 24-bit trigger words, port 0 lowest |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_port | input | 2 | Port targeted by the clear |
| clr_mask | input | 8 | Per-pin clear bits of the targeted port |
| int_status | output | 32 | Sticky per-pin status |
| bank_irq | output | 1 | Bank interrupt line |

## Verification
Corrupted status shows on `int_status` at the clock edge after the stimulus, because every status bit is one register stage from its pin. A corrupted previous-level flop appears as a missing or spurious edge one cycle after the pin moves. A wrong gate in the enable or OR path shows on `bank_irq` in the same cycle as the status it reflects. The race between a clear and an edge in the same cycle is the case most likely to hide a fault, so it is driven on purpose and also arises in the random stream.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef struct packed {
    logic both;
    logic edge_m;
    logic pol;
  } trig_cfg_t;

  function automatic logic trig_hit(trig_cfg_t c, logic cur, logic prv);
    logic r;
    if (!c.edge_m)    r = (cur == c.pol);
    else if (c.both)  r = cur ^ prv;
    else if (c.pol)   r = cur & ~prv;
    else              r = ~cur & prv;
    return r;
  endfunction

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  trig_cfg_t cfg,
  input  logic      clr,
  output logic      st
);

  logic prv;
  logic hit;

  assign hit = trig_hit(cfg, lvl, prv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv <= 1'b0;
      st  <= 1'b0;
    end else begin
      prv <= lvl;
      st  <= hit | (st & ~clr);
    end
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg.edge_m && !cfg.both && cfg.pol && lvl && !$past(lvl)) |=> st); // R3
  AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg.edge_m && !cfg.both && !cfg.pol && !lvl && $past(lvl)) |=> st); // R4
  AST_BOTH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg.edge_m && cfg.both && (lvl != $past(lvl))) |=> st); // R5
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.edge_m && (lvl == cfg.pol)) |=> st); // R6
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg.edge_m && $stable(lvl) && clr) |=> !st); // R7

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   lvl,
  input  logic [3*PINS-1:0] cfg_word,
  input  logic              clr_we,
  input  logic [PINS-1:0]   clr_mask,
  output logic [PINS-1:0]   st
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    trig_cfg_t c;
    assign c.pol    = cfg_word[i];
    assign c.edge_m = cfg_word[PINS + i];
    assign c.both   = cfg_word[2*PINS + i];

    gpio_irq_pin u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl[i]),
      .cfg   (c),
      .clr   (clr_we & clr_mask[i]),
      .st    (st[i])
    );
  end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  localparam int NPIN   = PORTS * PINS,
  localparam int CFGW   = 3 * PINS,
  localparam int PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIN-1:0]       pin_lvl,
  input  logic [NPIN-1:0]       irq_en,
  input  logic [PORTS*CFGW-1:0] trig_cfg,
  input  logic                  clr_we,
  input  logic [PSEL_W-1:0]     clr_port,
  input  logic [PINS-1:0]       clr_mask,
  output logic [NPIN-1:0]       int_status,
  output logic                  bank_irq
);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic sel;
    assign sel = clr_we && (clr_port == PSEL_W'(p));

    gpio_irq_port #(.PINS(PINS)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_lvl[p*PINS +: PINS]),
      .cfg_word (trig_cfg[p*CFGW +: CFGW]),
      .clr_we   (sel),
      .clr_mask (clr_mask),
      .st       (int_status[p*PINS +: PINS])
    );
  end

  assign bank_irq = |(int_status & irq_en);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !bank_irq); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_n && !$isunknown(int_status)) |-> (int_status == '0)); // R1

endmodule

// File: tb/sim_gpio_bank_irq.sv
module sim_gpio_bank_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lvl = '0;
  logic [31:0] en = '0;
  logic [95:0] cfg = '0;
  logic        cw = 1'b0;
  logic [1:0]  cp = '0;
  logic [7:0]  cm = '0;
  logic [31:0] st;
  logic        irq;

  logic [31:0] m_st = '0;
  logic [31:0] m_prev = '0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(lvl), .irq_en(en), .trig_cfg(cfg),
    .clr_we(cw), .clr_port(cp), .clr_mask(cm), .int_status(st), .bank_irq(irq)
  );

  function automatic logic [31:0] model_next(logic [31:0] s, logic [31:0] pv);
    logic [31:0] nx;
    for (int g = 0; g < 32; g++) begin
      int p = g / 8;
      int n = g % 8;
      logic pol = cfg[p*24 + n];
      logic ed  = cfg[p*24 + 8 + n];
      logic bo  = cfg[p*24 + 16 + n];
      logic hit;
      logic clr;
      if (!ed)     hit = (lvl[g] == pol);
      else if (bo) hit = lvl[g] ^ pv[g];
      else if (pol) hit = lvl[g] & ~pv[g];
      else         hit = ~lvl[g] & pv[g];
      clr = cw && (int'(cp) == p) && cm[n];
      nx[g] = hit | (s[g] & ~clr);
    end
    return nx;
  endfunction

  task automatic chk32(logic [31:0] got, logic [31:0] exp, string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_trig(int g, logic [2:0] code);
    cfg[(g/8)*24 + (g%8)]      = code[0];
    cfg[(g/8)*24 + 8 + (g%8)]  = code[1];
    cfg[(g/8)*24 + 16 + (g%8)] = code[2];
  endtask

  // Inputs already driven at negedge; advance one cycle and compare with model.
  task automatic step(string tag);
    logic [31:0] exp;
    exp = model_next(m_st, m_prev);
    @(posedge clk);
    m_prev = lvl;
    m_st = exp;
    #1;
    chk32(st, m_st, tag);
    chk32({31'b0, irq}, {31'b0, |(m_st & en)}, "R9 irq vs model");
    @(negedge clk);
    cw = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int g = 0; g < 32; g++) set_trig(g, 3'b011);
    repeat (3) @(posedge clk);
    #1;
    chk32(st, 32'h0, "R1 status in reset");
    chk32({31'b0, irq}, 32'h0, "R1 irq in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 idle after reset");
    chk32(st, 32'h0, "R1 no status after reset");

    // R3 rising on pin 5
    en = 32'hFFFF_FFFF;
    lvl[5] = 1'b1; step("R3 rise");
    chk32(st, 32'h20, "R3 rising sets bit5");
    chk32({31'b0, irq}, 32'h1, "R10 irq from port0");
    step("R3 hold");
    cw = 1'b1; cp = 2'd0; cm = 8'h20; step("R7 clear edge");
    chk32(st, 32'h0, "R7 clear drops rising status");

    // R8 clear and edge same cycle
    lvl[5] = 1'b0; step("R8 setup");
    lvl[5] = 1'b1; cw = 1'b1; cp = 2'd0; cm = 8'h20; step("R8 race");
    chk32(st, 32'h20, "R8 edge wins over clear");
    cw = 1'b1; cm = 8'h20; step("R7 clear");

    // R4 falling on pin 12 (port1 pin4)
    set_trig(12, 3'b010);
    lvl[12] = 1'b1; step("R4 rise ignored");
    chk32(st & 32'h1000, 32'h0, "R4 rising ignored in falling mode");
    lvl[12] = 1'b0; step("R4 fall");
    chk32(st & 32'h1000, 32'h1000, "R4 falling sets, R2 field position");

    // R7 zero mask and wrong port
    cw = 1'b1; cp = 2'd1; cm = 8'h00; step("R7 zero mask");
    chk32(st & 32'h1000, 32'h1000, "R7 zero mask no effect");
    cw = 1'b1; cp = 2'd2; cm = 8'h10; step("R7 other port");
    chk32(st & 32'h1000, 32'h1000, "R7 other port untouched");
    cw = 1'b1; cp = 2'd1; cm = 8'h10; step("R7 right port");
    chk32(st & 32'h1000, 32'h0, "R7 port1 pin4 cleared");

    // R5 both edges on pin 20
    set_trig(20, 3'b110);
    lvl[20] = 1'b1; step("R5 up");
    chk32(st & 32'h10_0000, 32'h10_0000, "R5 both-edge rising");
    cw = 1'b1; cp = 2'd2; cm = 8'h10; step("R7 clr");
    lvl[20] = 1'b0; step("R5 down");
    chk32(st & 32'h10_0000, 32'h10_0000, "R5 both-edge falling");
    cw = 1'b1; cp = 2'd2; cm = 8'h10; step("R7 clr");

    // R6 level high pin 30, level low pin 31
    set_trig(30, 3'b001); set_trig(31, 3'b000);
    lvl[31] = 1'b1;
    lvl[30] = 1'b1; step("R6 level");
    chk32(st & 32'hC000_0000, 32'h4000_0000, "R6 level high sets, low idle");
    cw = 1'b1; cp = 2'd3; cm = 8'hC0; step("R6 clear held");
    chk32(st & 32'hC000_0000, 32'h4000_0000, "R6 clear while held stays set");
    lvl[30] = 1'b0; lvl[31] = 1'b0; cw = 1'b1; cp = 2'd3; cm = 8'h40; step("R6 swap");
    chk32(st & 32'hC000_0000, 32'h8000_0000, "R6 level low sets after release");

    // R9 enable gating, R10 single high pin
    en = 32'h0; step("R9 disabled");
    chk32({31'b0, irq}, 32'h0, "R9 status kept, irq gated");
    chk32(st & 32'h8000_0000, 32'h8000_0000, "R9 status independent of enable");
    en = 32'h8000_0000; step("R10 pin31");
    chk32({31'b0, irq}, 32'h1, "R10 port3 pin7 raises irq");

    // Random phase: R3 R4 R5 R6 R7 R8 R9 checked against model each cycle
    for (int k = 0; k < 3000; k++) begin
      if (k % 64 == 0) begin
        for (int g = 0; g < 32; g++) begin
          case ($urandom % 5)
            0: set_trig(g, 3'b011);
            1: set_trig(g, 3'b010);
            2: set_trig(g, 3'b110);
            3: set_trig(g, 3'b001);
            default: set_trig(g, 3'b000);
          endcase
        end
      end
      lvl = lvl ^ ($urandom & $urandom & $urandom);
      en = $urandom;
      cw = ($urandom % 3 == 0);
      cp = 2'($urandom);
      cm = 8'($urandom);
      step("R3/R4/R5/R6/R7/R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule